// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder

This block finds the length of one instruction in a byte-granular, variable-length CISC encoding running with 32-bit defaults. It receives a 16-byte window whose byte 0 is the first byte of an instruction. It returns the total length of that instruction and the byte position of each field: opcode, ModR/M, SIB, displacement and immediate. A fetch or predecode stage uses the length to step to the next instruction boundary. It uses the field positions to extract operands without scanning the bytes again.

The length cannot be taken from the first byte. The block first walks a run of prefix bytes and records whether an operand-size or address-size override appears. Next it finds the opcode and checks for the 0F escape byte that selects the second opcode map. It classifies the opcode to learn whether a ModR/M byte follows and what kind of immediate the instruction carries. A second registered stage then decodes ModR/M and SIB to get the displacement size, applies the size overrides to the immediate, and adds up the fields. The two stages share a single stall, so a result appears two cycles after it was accepted whenever the consumer is ready.

In the window, byte i sits on bits [8i+7:8i].

Top module: `insn_len_decoder`

## Requirements
- R1: Prefix bytes are 26, 2E, 36, 3E, 64, 65, 66, 67, F0, F2 and F3 (hex). The run of prefixes starting at byte 0 is counted and reported as `out_pfx_cnt`. The opcode starts at byte `out_pfx_cnt`, and `out_opc_off` equals that count. A 66 anywhere in the counted run selects 16-bit operand size. A 67 anywhere in the counted run selects 16-bit addressing.
- R2: When bytes 0 to 5 are all prefixes, `out_err` is 1 and `out_pfx_cnt` is 5. Byte 5 is then decoded as the opcode, and its value does not affect the size overrides.
- R3: When the opcode byte is 0F, `out_two_byte` is 1 and the next byte is classified in the second map. `out_modrm_off` equals the opcode offset plus 2 when `out_two_byte` is 1, and plus 1 otherwise. `out_sib_off` equals `out_modrm_off` plus 1.
- R4: ModR/M has mod in bits 7:6, reg in bits 5:3 and rm in bits 2:0. In 32-bit addressing the rules are as follows. mod 11 adds nothing. mod 00 with rm 101 adds a 4-byte displacement. mod 01 adds 1 byte of displacement and mod 10 adds 4 bytes. rm 100 with any mod other than 11 adds a SIB byte. If no ModR/M byte is present, there is no SIB byte and no displacement.
- R5: When a SIB byte is present, mod is 00 and the SIB base field (bits 2:0) is 101, a 4-byte displacement is added.
- R6: Under 16-bit addressing there is never a SIB byte. mod 00 with rm 110 adds 2 bytes of displacement, mod 01 adds 1 byte and mod 10 adds 2 bytes.
- R7: In the first map, the following opcodes (hex) take ModR/M:
  - rows 00 to 3F where bits 2:0 are 0 to 3
  - 62, 63, 69, 6B
  - 80 to 8F
  - C0, C1, C4 to C7
  - D0 to D3, D8 to DF
  - F6, F7, FE, FF

  Every other first-map opcode has no ModR/M byte.
- R8: In the second map, the following opcodes have no ModR/M byte: 05 to 09, 0B, 30 to 37, 77, 80 to 8F, A0 to A2, A8 to AA and C8 to CF. Every other second-map opcode takes ModR/M.
- R9: Immediate size is `out_imm_len`. Let z be 4, or 2 with the operand-size override. Let a be 4, or 2 with the address-size override.
  - z: first-map 05-style rows (bits 2:0 = 5, below 40), 68, 69, 81, A9, B8 to BF, C7, E8 and E9; second-map 80 to 8F.
  - 1 byte: first-map 04-style rows, 6A, 6B, 70 to 7F, 80, 82, 83, A8, B0 to B7, C0, C1, C6, CD, D4, D5, E0 to E7 and EB; second-map 70 to 73, A4, AC, BA, C2 and C4 to C6.
  - 2 bytes: C2 and CA.
  - 3 bytes: C8.
  - a: A0 to A3.
  - z + 2: 9A and EA.
  - 0 bytes: all other opcodes.
- R10: F6 carries a 1-byte immediate, and F7 a z-sized immediate, only when the ModR/M reg field is 000 or 001. Otherwise F6 and F7 carry no immediate.
- R11: `out_disp_off` equals `out_modrm_off` plus 1 if ModR/M is present, plus 1 more if SIB is present. When ModR/M is absent, it equals `out_modrm_off`. `out_imm_off` equals `out_disp_off` plus `out_disp_len`. `out_len` equals `out_imm_off` plus `out_imm_len`. `out_err` is 1 when `out_len` exceeds 15.
- R12: `in_ready` is high whenever the output register is empty or `out_ready` is high. A window accepted in cycle t appears on the outputs in cycle t+2 if `out_ready` is high in cycle t+1. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R13: During reset and in the first cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Block can take a window this cycle |
| in_bytes | input | 128 | Instruction window, byte i on bits [8i+7:8i] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 5 | Total instruction length in bytes |
| out_pfx_cnt | output | 3 | Number of prefix bytes counted |
| out_two_byte | output | 1 | Opcode came from the escaped second map |
| out_has_modrm | output | 1 | ModR/M byte present |
| out_has_sib | output | 1 | SIB byte present |
| out_disp_len | output | 3 | Displacement size in bytes |
| out_imm_len | output | 3 | Immediate size in bytes |
| out_opc_off | output | 4 | Byte offset of the opcode |
| out_modrm_off | output | 4 | Byte offset of ModR/M |
| out_sib_off | output | 4 | Byte offset of SIB |
| out_disp_off | output | 4 | Byte offset of the displacement |
| out_imm_off | output | 4 | Byte offset of the immediate |
| out_err | output | 1 | Too many prefixes or length above 15 |

## Verification
The hardest case to reach from the ports is an instruction that overruns 15 bytes. It needs five prefixes, a ModR/M with mod 10 and a SIB byte, a 4-byte displacement and a full-size immediate, all at once. Uniform random bytes almost never produce that. The bench therefore builds windows from a prefix run of random length (zero to six entries drawn from the prefix list), an optional escape byte and a random opcode. It adds hand-built windows for the overrun, for the six-prefix overflow, for SIB base 101, for the 16-bit addressing forms and for both outcomes of the F6/F7 reg test. A reference model written from the requirements predicts every field, while random gaps on `in_valid` and random back-pressure on `out_ready` exercise stalls in both pipeline stages.

// File: rtl/ild_pkg.sv
// Shared types for the instruction length decoder.
// Assumes 32-bit default operand and address size.
package ild_pkg;

    // Kind of immediate an opcode carries, resolved to a byte count in stage 2
    typedef enum logic [3:0] {
        IMM_NONE  = 4'd0,
        IMM_B     = 4'd1,
        IMM_W     = 4'd2,
        IMM_Z     = 4'd3,
        IMM_WB    = 4'd4,
        IMM_MOFFS = 4'd5,
        IMM_PTR   = 4'd6,
        IMM_GRPB  = 4'd7,
        IMM_GRPZ  = 4'd8
    } imm_kind_e;

    typedef struct packed {
        logic      needs_modrm;
        imm_kind_e imm;
    } opc_info_t;

    localparam logic [7:0] ESCAPE_BYTE = 8'h0F;

endpackage

// File: rtl/ild_prefix_scan.sv
// Prefix scanner: counts the run of prefix bytes from byte 0 of the window
// and records size overrides. Looks at SCAN_BYTES bytes; a run covering all
// of them is an overflow, with the count capped at SCAN_BYTES-1.
// Assumes SCAN_BYTES >= 2.
module ild_prefix_scan #(
    parameter int SCAN_BYTES = 6,
    localparam int CNT_W = $clog2(SCAN_BYTES)
) (
    input  logic [SCAN_BYTES*8-1:0] bytes_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    overflow_o,
    output logic                    opsz16_o,
    output logic                    adsz16_o
);

    logic [SCAN_BYTES-1:0] is_pfx;
    logic [SCAN_BYTES-1:0] is_opsz;
    logic [SCAN_BYTES-1:0] is_adsz;

    // One recogniser per scanned byte position
    for (genvar g = 0; g < SCAN_BYTES; g++) begin : g_rec
        logic [7:0] b;
        assign b = bytes_i[g*8 +: 8];
        always_comb begin : p_rec  // classify one byte as prefix or not
            unique case (b)
                8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: is_pfx[g] = 1'b1;
                default:                           is_pfx[g] = 1'b0;
            endcase
        end
        assign is_opsz[g] = (b == 8'h66);
        assign is_adsz[g] = (b == 8'h67);
    end

    // Walk the run in order; stop at the first non-prefix byte
    always_comb begin : p_walk
        logic run;
        run        = 1'b1;
        cnt_o      = '0;
        opsz16_o   = 1'b0;
        adsz16_o   = 1'b0;
        for (int i = 0; i < SCAN_BYTES - 1; i++) begin
            if (run && is_pfx[i]) begin
                cnt_o    = cnt_o + CNT_W'(1);
                opsz16_o = opsz16_o | is_opsz[i];
                adsz16_o = adsz16_o | is_adsz[i];
            end else begin
                run = 1'b0;
            end
        end
        overflow_o = run && is_pfx[SCAN_BYTES-1];
    end

endmodule

// File: rtl/ild_opcode_class.sv
// Opcode classifier: for a first-map or second-map opcode, says whether a
// ModR/M byte follows and what kind of immediate is carried.
// Covers a representative opcode subset; unknown opcodes fall to defaults.
module ild_opcode_class
    import ild_pkg::*;
(
    input  logic       two_byte_i,
    input  logic [7:0] opc_i,
    output opc_info_t  info_o
);

    // First-map classification
    function automatic opc_info_t map_one(input logic [7:0] op);
        opc_info_t r;
        r.needs_modrm = 1'b0;
        r.imm         = IMM_NONE;
        casez (op)
            8'b00??_?0??: r.needs_modrm = 1'b1;
            8'b00??_?100: r.imm = IMM_B;
            8'b00??_?101: r.imm = IMM_Z;
            8'h62, 8'h63: r.needs_modrm = 1'b1;
            8'h68:        r.imm = IMM_Z;
            8'h69: begin r.needs_modrm = 1'b1; r.imm = IMM_Z; end
            8'h6A:        r.imm = IMM_B;
            8'h6B: begin r.needs_modrm = 1'b1; r.imm = IMM_B; end
            8'b0111_????: r.imm = IMM_B;
            8'h80, 8'h82, 8'h83: begin r.needs_modrm = 1'b1; r.imm = IMM_B; end
            8'h81: begin r.needs_modrm = 1'b1; r.imm = IMM_Z; end
            8'b1000_01??, 8'b1000_1???: r.needs_modrm = 1'b1;
            8'h9A, 8'hEA: r.imm = IMM_PTR;
            8'b1010_00??: r.imm = IMM_MOFFS;
            8'hA8:        r.imm = IMM_B;
            8'hA9:        r.imm = IMM_Z;
            8'b1011_0???: r.imm = IMM_B;
            8'b1011_1???: r.imm = IMM_Z;
            8'hC0, 8'hC1, 8'hC6: begin r.needs_modrm = 1'b1; r.imm = IMM_B; end
            8'hC7: begin r.needs_modrm = 1'b1; r.imm = IMM_Z; end
            8'hC2, 8'hCA: r.imm = IMM_W;
            8'hC8:        r.imm = IMM_WB;
            8'hC4, 8'hC5: r.needs_modrm = 1'b1;
            8'hCD:        r.imm = IMM_B;
            8'b1101_00??, 8'b1101_1???: r.needs_modrm = 1'b1;
            8'hD4, 8'hD5: r.imm = IMM_B;
            8'b1110_0???, 8'hEB: r.imm = IMM_B;
            8'hE8, 8'hE9: r.imm = IMM_Z;
            8'hF6: begin r.needs_modrm = 1'b1; r.imm = IMM_GRPB; end
            8'hF7: begin r.needs_modrm = 1'b1; r.imm = IMM_GRPZ; end
            8'hFE, 8'hFF: r.needs_modrm = 1'b1;
            default: ;
        endcase
        return r;
    endfunction

    // Second-map classification
    function automatic opc_info_t map_two(input logic [7:0] op);
        opc_info_t r;
        r.needs_modrm = 1'b1;
        r.imm         = IMM_NONE;
        casez (op)
            8'b1000_????: begin r.needs_modrm = 1'b0; r.imm = IMM_Z; end
            8'b0111_00??, 8'hA4, 8'hAC, 8'hBA, 8'hC2,
            8'hC4, 8'hC5, 8'hC6: r.imm = IMM_B;
            8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0B,
            8'b0011_0???, 8'h77, 8'hA0, 8'hA1, 8'hA2,
            8'hA8, 8'hA9, 8'hAA, 8'b1100_1???: r.needs_modrm = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    // Select the map the escape byte picked
    always_comb begin : p_sel
        info_o = two_byte_i ? map_two(opc_i) : map_one(opc_i);
    end

endmodule

// File: rtl/ild_modrm_size.sv
// Addressing-form decoder: from ModR/M, SIB and the address size, gives the
// presence of a SIB byte and the displacement size. Assumes a ModR/M byte is
// present; the caller gates the results otherwise.
module ild_modrm_size (
    input  logic [7:0] modrm_i,
    input  logic [7:0] sib_i,
    input  logic       adsz16_i,
    output logic       has_sib_o,
    output logic [2:0] disp_len_o
);

    logic [1:0] md;
    logic [2:0] rm;
    assign md = modrm_i[7:6];
    assign rm = modrm_i[2:0];

    // Apply the 16-bit or 32-bit addressing rules
    always_comb begin : p_size
        has_sib_o  = 1'b0;
        disp_len_o = 3'd0;
        if (adsz16_i) begin
            unique case (md)
                2'b00:   disp_len_o = (rm == 3'b110) ? 3'd2 : 3'd0;
                2'b01:   disp_len_o = 3'd1;
                2'b10:   disp_len_o = 3'd2;
                default: disp_len_o = 3'd0;
            endcase
        end else begin
            has_sib_o = (md != 2'b11) && (rm == 3'b100);
            unique case (md)
                2'b00: begin
                    if (rm == 3'b101)
                        disp_len_o = 3'd4;
                    else if (rm == 3'b100 && sib_i[2:0] == 3'b101)
                        disp_len_o = 3'd4;
                    else
                        disp_len_o = 3'd0;
                end
                2'b01:   disp_len_o = 3'd1;
                2'b10:   disp_len_o = 3'd4;
                default: disp_len_o = 3'd0;
            endcase
        end
    end

endmodule

// File: rtl/insn_len_decoder.sv
// Instruction length decoder, two pipeline stages under one stall.
// Stage 1: prefix run, escape, opcode class, ModR/M and SIB byte pick.
// Stage 2: addressing form, immediate size, field offsets, length, error.
// Assumes byte 0 of the window is an instruction boundary.
module insn_len_decoder
    import ild_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int MAX_PFX   = 5,
    parameter int MAX_LEN   = 15,
    localparam int OFF_W    = $clog2(WIN_BYTES),
    localparam int LEN_W    = OFF_W + 1,
    localparam int PC_W     = $clog2(MAX_PFX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WIN_BYTES*8-1:0] in_bytes,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LEN_W-1:0]       out_len,
    output logic [PC_W-1:0]        out_pfx_cnt,
    output logic                   out_two_byte,
    output logic                   out_has_modrm,
    output logic                   out_has_sib,
    output logic [2:0]             out_disp_len,
    output logic [2:0]             out_imm_len,
    output logic [OFF_W-1:0]       out_opc_off,
    output logic [OFF_W-1:0]       out_modrm_off,
    output logic [OFF_W-1:0]       out_sib_off,
    output logic [OFF_W-1:0]       out_disp_off,
    output logic [OFF_W-1:0]       out_imm_off,
    output logic                   out_err
);

    localparam int SCAN_BYTES = MAX_PFX + 1;

    logic en;
    assign en       = !out_valid || out_ready;
    assign in_ready = en;

    // ---------------- stage 1 ----------------
    logic [PC_W-1:0]  s0_pc;
    logic             s0_ovf, s0_o16, s0_a16;
    logic [OFF_W-1:0] s0_pc_idx, s0_m_idx;
    logic [7:0]       s0_b0, s0_b1, s0_opc, s0_modrm, s0_sib;
    logic             s0_two;
    opc_info_t        s0_info;

    ild_prefix_scan #(.SCAN_BYTES(SCAN_BYTES)) u_pfx (
        .bytes_i    (in_bytes[SCAN_BYTES*8-1:0]),
        .cnt_o      (s0_pc),
        .overflow_o (s0_ovf),
        .opsz16_o   (s0_o16),
        .adsz16_o   (s0_a16)
    );

    // Locate opcode, escape and the ModR/M and SIB candidates
    always_comb begin : p_pick
        s0_pc_idx = OFF_W'(s0_pc);
        s0_b0     = in_bytes[{s0_pc_idx, 3'b000} +: 8];
        s0_b1     = in_bytes[{s0_pc_idx + OFF_W'(1), 3'b000} +: 8];
        s0_two    = (s0_b0 == ESCAPE_BYTE);
        s0_opc    = s0_two ? s0_b1 : s0_b0;
        s0_m_idx  = s0_pc_idx + OFF_W'(1) + OFF_W'(s0_two);
        s0_modrm  = in_bytes[{s0_m_idx, 3'b000} +: 8];
        s0_sib    = in_bytes[{s0_m_idx + OFF_W'(1), 3'b000} +: 8];
    end

    ild_opcode_class u_cls (
        .two_byte_i (s0_two),
        .opc_i      (s0_opc),
        .info_o     (s0_info)
    );

    logic             s1_valid, s1_ovf, s1_o16, s1_a16, s1_two;
    logic [PC_W-1:0]  s1_pc;
    logic [OFF_W-1:0] s1_m_idx;
    logic [7:0]       s1_modrm, s1_sib;
    opc_info_t        s1_info;

    // Stage 1 register, advancing only when the pipe is not stalled
    always_ff @(posedge clk) begin : p_s1
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ovf   <= 1'b0;
            s1_o16   <= 1'b0;
            s1_a16   <= 1'b0;
            s1_two   <= 1'b0;
            s1_pc    <= '0;
            s1_m_idx <= '0;
            s1_modrm <= '0;
            s1_sib   <= '0;
            s1_info  <= '{needs_modrm: 1'b0, imm: IMM_NONE};
        end else if (en) begin
            s1_valid <= in_valid;
            s1_ovf   <= s0_ovf;
            s1_o16   <= s0_o16;
            s1_a16   <= s0_a16;
            s1_two   <= s0_two;
            s1_pc    <= s0_pc;
            s1_m_idx <= s0_m_idx;
            s1_modrm <= s0_modrm;
            s1_sib   <= s0_sib;
            s1_info  <= s0_info;
        end
    end

    // ---------------- stage 2 ----------------
    logic       am_sib;
    logic [2:0] am_disp;

    ild_modrm_size u_am (
        .modrm_i    (s1_modrm),
        .sib_i      (s1_sib),
        .adsz16_i   (s1_a16),
        .has_sib_o  (am_sib),
        .disp_len_o (am_disp)
    );

    logic             s2_sib;
    logic [2:0]       s2_disp, s2_imm, z_len, a_len;
    logic             grp_imm;
    logic [OFF_W-1:0] s2_disp_off, s2_imm_off;
    logic [LEN_W-1:0] s2_len;

    // Resolve immediate size from its kind and the size overrides
    always_comb begin : p_imm
        z_len   = s1_o16 ? 3'd2 : 3'd4;
        a_len   = s1_a16 ? 3'd2 : 3'd4;
        grp_imm = (s1_modrm[5:4] == 2'b00);
        unique case (s1_info.imm)
            IMM_B:     s2_imm = 3'd1;
            IMM_W:     s2_imm = 3'd2;
            IMM_Z:     s2_imm = z_len;
            IMM_WB:    s2_imm = 3'd3;
            IMM_MOFFS: s2_imm = a_len;
            IMM_PTR:   s2_imm = z_len + 3'd2;
            IMM_GRPB:  s2_imm = grp_imm ? 3'd1 : 3'd0;
            IMM_GRPZ:  s2_imm = grp_imm ? z_len : 3'd0;
            default:   s2_imm = 3'd0;
        endcase
    end

    // Place the fields and sum the length
    always_comb begin : p_sum
        s2_sib      = s1_info.needs_modrm && am_sib;
        s2_disp     = s1_info.needs_modrm ? am_disp : 3'd0;
        s2_disp_off = s1_m_idx + OFF_W'(s1_info.needs_modrm) + OFF_W'(s2_sib);
        s2_imm_off  = s2_disp_off + OFF_W'(s2_disp);
        s2_len      = LEN_W'(s2_imm_off) + LEN_W'(s2_imm);
    end

    // Output register, held while the consumer stalls
    always_ff @(posedge clk) begin : p_out
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_len       <= '0;
            out_pfx_cnt   <= '0;
            out_two_byte  <= 1'b0;
            out_has_modrm <= 1'b0;
            out_has_sib   <= 1'b0;
            out_disp_len  <= '0;
            out_imm_len   <= '0;
            out_opc_off   <= '0;
            out_modrm_off <= '0;
            out_sib_off   <= '0;
            out_disp_off  <= '0;
            out_imm_off   <= '0;
            out_err       <= 1'b0;
        end else if (en) begin
            out_valid     <= s1_valid;
            out_len       <= s2_len;
            out_pfx_cnt   <= s1_pc;
            out_two_byte  <= s1_two;
            out_has_modrm <= s1_info.needs_modrm;
            out_has_sib   <= s2_sib;
            out_disp_len  <= s2_disp;
            out_imm_len   <= s2_imm;
            out_opc_off   <= OFF_W'(s1_pc);
            out_modrm_off <= s1_m_idx;
            out_sib_off   <= s1_m_idx + OFF_W'(1);
            out_disp_off  <= s2_disp_off;
            out_imm_off   <= s2_imm_off;
            out_err       <= s1_ovf || (s2_len > LEN_W'(MAX_LEN));
        end
    end

endmodule

// File: rtl/ild_checker.sv
// Protocol and consistency properties for insn_len_decoder, bound to it.
module ild_checker #(
    parameter int LEN_W = 5,
    parameter int PC_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LEN_W-1:0] out_len,
    input logic [PC_W-1:0]  out_pfx_cnt,
    input logic             out_has_modrm,
    input logic             out_has_sib,
    input logic [2:0]       out_disp_len,
    input logic [2:0]       out_imm_len,
    input logic             out_err
);

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 out_ready |=> out_valid);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_err)
                                        && $stable(out_imm_len)));

    p_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid) |-> in_ready);

    p_sib_modrm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_has_sib) |-> out_has_modrm);

    p_disp_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_disp_len == 3'd0 || out_disp_len == 3'd1 ||
                       out_disp_len == 3'd2 || out_disp_len == 3'd4));

    p_pfx_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pfx_cnt <= PC_W'(5)));

    p_long_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len > LEN_W'(15)) |-> out_err);

    p_imm_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_imm_len <= 3'd6));

    p_reset_r13: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind insn_len_decoder ild_checker u_chk (.*);

// File: tb/insn_len_decoder_tb.sv
// Bench: behavioural reference model, random stalls, per-clock comparison.
module insn_len_decoder_tb;

    localparam int K_NONE = 0, K_B = 1, K_W = 2, K_Z = 3, K_WB = 4,
                   K_A = 5, K_P = 6, K_GB = 7, K_GZ = 8;

    typedef struct {
        int len, pfx, two, hm, hs, dl, il, oo, mo, so, dof, iof, err;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_bytes = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [4:0]   out_len;
    logic [2:0]   out_pfx_cnt;
    logic         out_two_byte, out_has_modrm, out_has_sib, out_err;
    logic [2:0]   out_disp_len, out_imm_len;
    logic [3:0]   out_opc_off, out_modrm_off, out_sib_off, out_disp_off, out_imm_off;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    logic [127:0] stim_q[$];
    exp_t         exp_q[$];

    always #2.5 clk = ~clk;

    insn_len_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
        .out_len(out_len), .out_pfx_cnt(out_pfx_cnt), .out_two_byte(out_two_byte),
        .out_has_modrm(out_has_modrm), .out_has_sib(out_has_sib),
        .out_disp_len(out_disp_len), .out_imm_len(out_imm_len),
        .out_opc_off(out_opc_off), .out_modrm_off(out_modrm_off),
        .out_sib_off(out_sib_off), .out_disp_off(out_disp_off),
        .out_imm_off(out_imm_off), .out_err(out_err)
    );

    function automatic bit is_prefix(input int b);
        return b == 'h26 || b == 'h2E || b == 'h36 || b == 'h3E || b == 'h64 ||
               b == 'h65 || b == 'h66 || b == 'h67 || b == 'hF0 || b == 'hF2 ||
               b == 'hF3;
    endfunction

    // R7 and R9 first map, R8 and R9 second map
    function automatic void classify(input bit two, input int op, output bit m, output int k);
        m = 0; k = K_NONE;
        if (!two) begin
            if (op < 'h40) begin
                if ((op & 4) == 0) m = 1;
                else if ((op & 7) == 4) k = K_B;
                else if ((op & 7) == 5) k = K_Z;
            end
            else if (op == 'h62 || op == 'h63) m = 1;
            else if (op == 'h68) k = K_Z;
            else if (op == 'h69) begin m = 1; k = K_Z; end
            else if (op == 'h6A) k = K_B;
            else if (op == 'h6B) begin m = 1; k = K_B; end
            else if (op >= 'h70 && op <= 'h7F) k = K_B;
            else if (op == 'h80 || op == 'h82 || op == 'h83) begin m = 1; k = K_B; end
            else if (op == 'h81) begin m = 1; k = K_Z; end
            else if (op >= 'h84 && op <= 'h8F) m = 1;
            else if (op == 'h9A || op == 'hEA) k = K_P;
            else if (op >= 'hA0 && op <= 'hA3) k = K_A;
            else if (op == 'hA8) k = K_B;
            else if (op == 'hA9) k = K_Z;
            else if (op >= 'hB0 && op <= 'hB7) k = K_B;
            else if (op >= 'hB8 && op <= 'hBF) k = K_Z;
            else if (op == 'hC0 || op == 'hC1 || op == 'hC6) begin m = 1; k = K_B; end
            else if (op == 'hC7) begin m = 1; k = K_Z; end
            else if (op == 'hC2 || op == 'hCA) k = K_W;
            else if (op == 'hC8) k = K_WB;
            else if (op == 'hC4 || op == 'hC5) m = 1;
            else if (op == 'hCD) k = K_B;
            else if ((op >= 'hD0 && op <= 'hD3) || (op >= 'hD8 && op <= 'hDF)) m = 1;
            else if (op == 'hD4 || op == 'hD5) k = K_B;
            else if ((op >= 'hE0 && op <= 'hE7) || op == 'hEB) k = K_B;
            else if (op == 'hE8 || op == 'hE9) k = K_Z;
            else if (op == 'hF6) begin m = 1; k = K_GB; end
            else if (op == 'hF7) begin m = 1; k = K_GZ; end
            else if (op == 'hFE || op == 'hFF) m = 1;
        end else begin
            m = 1;
            if (op >= 'h80 && op <= 'h8F) begin m = 0; k = K_Z; end
            else if ((op >= 'h70 && op <= 'h73) || op == 'hA4 || op == 'hAC ||
                     op == 'hBA || op == 'hC2 || (op >= 'hC4 && op <= 'hC6)) k = K_B;
            else if ((op >= 'h05 && op <= 'h09) || op == 'h0B ||
                     (op >= 'h30 && op <= 'h37) || op == 'h77 ||
                     (op >= 'hA0 && op <= 'hA2) || (op >= 'hA8 && op <= 'hAA) ||
                     (op >= 'hC8 && op <= 'hCF)) m = 0;
        end
    endfunction

    function automatic exp_t model(input logic [127:0] w);
        exp_t e;
        int pc = 0, op, mr, sb, md, rm, k, z, a;
        bit o16 = 0, a16 = 0, ovf = 0, two, m;
        for (int i = 0; i < 6; i++) begin   // R1 prefix run, R2 overflow
            int b = int'(w[8*i +: 8]);
            if (!is_prefix(b)) break;
            if (i == 5) begin ovf = 1; break; end
            pc++;
            if (b == 'h66) o16 = 1;
            if (b == 'h67) a16 = 1;
        end
        two = (w[8*pc +: 8] == 8'h0F);          // R3
        op  = int'(w[8*(pc + int'(two)) +: 8]);
        e.mo = pc + 1 + int'(two);
        mr  = int'(w[8*e.mo +: 8]);
        sb  = int'(w[8*(e.mo + 1) +: 8]);
        classify(two, op, m, k);
        md = (mr >> 6) & 3; rm = mr & 7;
        e.hs = 0; e.dl = 0;
        if (m) begin
            if (a16) begin                       // R6
                if (md == 0 && rm == 6) e.dl = 2;
                else if (md == 1) e.dl = 1;
                else if (md == 2) e.dl = 2;
            end else begin                       // R4, R5
                if (md != 3 && rm == 4) e.hs = 1;
                if (md == 0 && rm == 5) e.dl = 4;
                else if (md == 0 && e.hs == 1 && (sb & 7) == 5) e.dl = 4;
                else if (md == 1) e.dl = 1;
                else if (md == 2) e.dl = 4;
            end
        end
        z = o16 ? 2 : 4; a = a16 ? 2 : 4;
        case (k)                                 // R9, R10
            K_B: e.il = 1;
            K_W: e.il = 2;
            K_Z: e.il = z;
            K_WB: e.il = 3;
            K_A: e.il = a;
            K_P: e.il = z + 2;
            K_GB: e.il = (((mr >> 3) & 7) < 2) ? 1 : 0;
            K_GZ: e.il = (((mr >> 3) & 7) < 2) ? z : 0;
            default: e.il = 0;
        endcase
        e.pfx = pc; e.two = int'(two); e.hm = int'(m); e.oo = pc;
        e.so  = e.mo + 1;
        e.dof = e.mo + int'(m) + e.hs;           // R11
        e.iof = e.dof + e.dl;
        e.len = e.iof + e.il;
        e.err = (ovf || e.len > 15) ? 1 : 0;
        return e;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_result(input exp_t e);
        cmp("R11", "len", int'(out_len), e.len);
        cmp("R1", "pfx_cnt", int'(out_pfx_cnt), e.pfx);
        cmp("R1", "opc_off", int'(out_opc_off), e.oo);
        cmp("R3", "two_byte", int'(out_two_byte), e.two);
        cmp("R3", "modrm_off", int'(out_modrm_off), e.mo);
        cmp("R3", "sib_off", int'(out_sib_off), e.so);
        cmp("R7", "has_modrm", int'(out_has_modrm), e.hm);
        cmp("R4", "has_sib", int'(out_has_sib), e.hs);
        cmp("R5", "disp_len", int'(out_disp_len), e.dl);
        cmp("R9", "imm_len", int'(out_imm_len), e.il);
        cmp("R11", "disp_off", int'(out_disp_off), e.dof);
        cmp("R11", "imm_off", int'(out_imm_off), e.iof);
        cmp("R2", "err", int'(out_err), e.err);
    endtask

    task automatic add_bytes(input logic [7:0] q[$]);
        logic [127:0] w = '0;
        foreach (q[i]) w[8*i +: 8] = q[i];
        stim_q.push_back(w);
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin : p_watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin : p_main
        logic [7:0] q[$];
        logic [7:0] pl[11] = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
                               8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
        bit mv1 = 0, mov = 0, acc = 0;

        // Directed windows
        q = {8'h90};                                           add_bytes(q); // R7
        q = {8'h66, 8'hB8, 8'h11, 8'h22};                      add_bytes(q); // R9 R1
        q = {8'hB8, 8'h01, 8'h02, 8'h03, 8'h04};               add_bytes(q); // R9
        q = {8'h0F, 8'h84, 8'h00, 8'h00, 8'h00, 8'h00};        add_bytes(q); // R8 R3
        q = {8'h66, 8'h0F, 8'h84, 8'h00, 8'h00};               add_bytes(q); // R8
        q = {8'h8B, 8'h04, 8'h25, 8'h00, 8'h00, 8'h00, 8'h00}; add_bytes(q); // R5
        q = {8'h8B, 8'h44, 8'h24, 8'h08};                      add_bytes(q); // R4
        q = {8'h8B, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00};        add_bytes(q); // R4
        q = {8'h8B, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};        add_bytes(q); // R4
        q = {8'h8B, 8'hC0};                                    add_bytes(q); // R4
        q = {8'h67, 8'h8B, 8'h06, 8'h34, 8'h12};               add_bytes(q); // R6
        q = {8'h67, 8'h8B, 8'h04};                             add_bytes(q); // R6
        q = {8'h67, 8'h8B, 8'h84, 8'h00, 8'h00};               add_bytes(q); // R6
        q = {8'h67, 8'hA1, 8'h00, 8'h00};                      add_bytes(q); // R9
        q = {8'hF7, 8'hC0, 8'h01, 8'h00, 8'h00, 8'h00};        add_bytes(q); // R10
        q = {8'hF7, 8'hD0};                                    add_bytes(q); // R10
        q = {8'hF6, 8'hC8, 8'h01};                             add_bytes(q); // R10
        q = {8'hF6, 8'hE0};                                    add_bytes(q); // R10
        q = {8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h90}; add_bytes(q); // R2
        q = {8'h2E, 8'h2E, 8'h2E, 8'h2E, 8'h2E, 8'h67, 8'h8B, 8'h06}; add_bytes(q); // R2
        q = {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'hC7, 8'h84, 8'h24,
             8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00};      add_bytes(q); // R11
        q = {8'hF0, 8'hF2, 8'hF3, 8'h65, 8'h90};               add_bytes(q); // R1
        q = {8'hC8, 8'h10, 8'h00, 8'h01};                      add_bytes(q); // R9
        q = {8'h0F, 8'hBA, 8'hE0, 8'h05};                      add_bytes(q); // R8
        q = {8'h0F, 8'hA2};                                    add_bytes(q); // R8
        q = {8'h66, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h00};        add_bytes(q); // R9

        // Structured random windows
        for (int n = 0; n < 3000; n++) begin
            logic [127:0] w;
            int np, pos;
            for (int b = 0; b < 16; b++) w[8*b +: 8] = 8'($urandom);
            np = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : $urandom_range(0, 2);
            for (int b = 0; b < np; b++) w[8*b +: 8] = pl[$urandom_range(0, 10)];
            pos = np;
            if (np < 6 && is_prefix(int'(w[8*pos +: 8]))) w[8*pos +: 8] = 8'h90;
            if (np < 6 && $urandom_range(0, 3) == 0) w[8*pos +: 8] = 8'h0F;
            stim_q.push_back(w);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R13", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R13", "out_valid after reset", int'(out_valid), 0);

        while (stim_q.size() > 0 || in_valid || exp_q.size() > 0) begin
            bit en;
            if (acc) begin in_valid = 1'b0; acc = 0; end
            if (!in_valid && stim_q.size() > 0 && $urandom_range(0, 3) != 0) begin
                in_bytes = stim_q.pop_front();
                in_valid = 1'b1;
            end
            out_ready = ($urandom_range(0, 4) != 0);
            #1;
            en = !mov || out_ready;
            cmp("R12", "out_valid", int'(out_valid), int'(mov));
            cmp("R12", "in_ready", int'(in_ready), int'(en));
            if (out_valid && out_ready && exp_q.size() > 0) check_result(exp_q.pop_front());
            if (in_valid && in_ready) begin
                exp_q.push_back(model(in_bytes));
                acc = 1;
            end
            if (en) begin mov = mv1; mv1 = in_valid; end
            @(negedge clk);
        end
        done = 1'b1;
        report();
    end

endmodule